// File: doc/BRIEF.md
# Bit-Masked Write-Merge RAM Wrapper

This block places a single-port style request interface with a per-bit write mask in front of a plain two-port array (one read port, one write port) that only writes whole words. Each cycle the caller may issue one request, either a read or a write, carrying an address, a data word and a bit mask. A write reads the addressed word in the request cycle. In the following cycle it merges the new data into that word under the mask and commits the result through the write port.

Because a write commits one cycle late, the block tracks the word it is about to commit. A request to the same address in the very next cycle takes that merged word instead of the stale array output. This holds both for reads and for further masked writes. Read data is due one cycle after the read request. Depth and width are parameters. The intended shapes range from 128x80 up to 4096x144.

A three-state pipeline stage drives the sequencing. ST_IDLE means no request was accepted last cycle. ST_READ means a read is returning data this cycle. ST_MERGE means a write is merging and committing this cycle. The next state depends only on the request of the current cycle. No request leads to ST_IDLE, a read leads to ST_READ and a write leads to ST_MERGE, whatever the current state is. Reset forces ST_IDLE.

Top module: `bitmask_ram`

## Requirements
- R1: A read request in cycle t raises rd_valid for cycle t+1 only, with rd_data holding the addressed word. rd_valid is low in the cycle after a write or an idle cycle.
- R2: A write request in cycle t with data D and mask M stores (old AND NOT M) OR (D AND M) at its address. A mask bit of 1 selects the new data bit, and the commit happens in cycle t+1.
- R3: A read in cycle t+1 of the address written in cycle t returns the merged word, not the array's stale content.
- R4: A read issued two or more cycles after a write to the same address returns the merged word.
- R5: A run of consecutive writes to one address merges each write against the result of the previous one.
- R6: A write with an all-zero mask leaves the word unchanged. A write with an all-ones mask replaces it entirely.
- R7: While reset is asserted, rd_valid is low and no write is committed. Array contents are undefined after reset.
- R8: The merged word is forwarded only when the addresses match. A request to a different address right after a write sees that other address's own content.
- R9: A cycle with no request changes no stored word and raises no rd_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline stage |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = masked write, 0 = read |
| req_addr | input | AW | Word address, AW = clog2(DEPTH) |
| req_wdata | input | WIDTH | Write data |
| req_mask | input | WIDTH | Per-bit write mask, 1 = take the new bit |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | WIDTH | Read data |

## Verification
Read results are due exactly one clock after the read request. No register lies between the pipeline stage and the outputs, so the bench drives each request half a cycle before an edge. It then samples rd_valid and rd_data at the next falling edge, which is the cycle the request's result is due. A write has no port-visible result of its own. Its effect is observed by reads placed zero, one or more cycles after it, so the forwarded path (the next cycle) and the committed path (two or more cycles later) are each checked against a bench model that applies the masked-merge formula.

// File: rtl/bmram_pkg.sv
package bmram_pkg;

    // State of the one-deep request stage
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_MERGE = 2'd2
    } stage_e;

endpackage

// File: rtl/bmram_store.sv
// Whole-word two-port array: one synchronous read port, one write port.
module bmram_store #(
    parameter int DEPTH = 128,
    parameter int WIDTH = 80,
    parameter int AW    = 7
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_q
);

    logic [WIDTH-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end
        if (rd_en) begin
            rd_q <= cells[rd_addr];
        end
    end

endmodule

// File: rtl/bmram_merge.sv
// Per-bit select between the old word and the new data under the mask.
module bmram_merge #(
    parameter int WIDTH = 80
) (
    input  logic [WIDTH-1:0] old_word,
    input  logic [WIDTH-1:0] new_word,
    input  logic [WIDTH-1:0] bit_sel,
    output logic [WIDTH-1:0] merged
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign merged[b] = bit_sel[b] ? new_word[b] : old_word[b];
    end

endmodule

// File: rtl/bmram_bypass.sv
// Holds the word committed last cycle when the current request hits its address,
// and selects it over the array output in the following cycle.
module bmram_bypass #(
    parameter int WIDTH = 80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [WIDTH-1:0] cap_word,
    input  logic [WIDTH-1:0] ram_q,
    output logic [WIDTH-1:0] cur_word
);

    logic             hit_q;
    logic [WIDTH-1:0] held_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_q  <= 1'b0;
            held_q <= '0;
        end else begin
            hit_q <= capture;
            if (capture) begin
                held_q <= cap_word;
            end
        end
    end

    assign cur_word = hit_q ? held_q : ram_q;

endmodule

// File: rtl/bitmask_ram.sv
module bitmask_ram #(
    parameter int DEPTH = 128,
    parameter int WIDTH = 80,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [WIDTH-1:0] req_wdata,
    input  logic [WIDTH-1:0] req_mask,
    output logic             rd_valid,
    output logic [WIDTH-1:0] rd_data
);

    import bmram_pkg::*;

    stage_e           state_q, state_d;
    logic [AW-1:0]    addr_q;
    logic [WIDTH-1:0] wdata_q;
    logic [WIDTH-1:0] mask_q;

    logic             wr_en;
    logic [WIDTH-1:0] wr_word;
    logic [WIDTH-1:0] ram_q;
    logic [WIDTH-1:0] cur_word;
    logic             fwd_capture;

    // Next state follows the request of this cycle
    always_comb begin
        state_d = ST_IDLE;
        if (req_valid) begin
            state_d = req_write ? ST_MERGE : ST_READ;
        end
    end

    // State register and captured request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
        end else begin
            state_q <= state_d;
            if (req_valid) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                mask_q  <= req_mask;
            end
        end
    end

    // Outputs per state
    always_comb begin
        wr_en    = 1'b0;
        rd_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_READ:  rd_valid = 1'b1;
            ST_MERGE: wr_en    = 1'b1;
            default:  ;
        endcase
    end

    assign fwd_capture = wr_en && req_valid && (req_addr == addr_q);
    assign rd_data     = cur_word;

    bmram_store #(
        .DEPTH (DEPTH),
        .WIDTH (WIDTH),
        .AW    (AW)
    ) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (addr_q),
        .wr_data (wr_word),
        .rd_en   (req_valid),
        .rd_addr (req_addr),
        .rd_q    (ram_q)
    );

    bmram_bypass #(
        .WIDTH (WIDTH)
    ) u_bypass (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (fwd_capture),
        .cap_word (wr_word),
        .ram_q    (ram_q),
        .cur_word (cur_word)
    );

    bmram_merge #(
        .WIDTH (WIDTH)
    ) u_merge (
        .old_word (cur_word),
        .new_word (wdata_q),
        .bit_sel  (mask_q),
        .merged   (wr_word)
    );

endmodule

// File: rtl/bmram_chk.sv
module bmram_chk #(
    parameter int WIDTH = 80,
    parameter int AW    = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic [AW-1:0]    req_addr,
    input logic [WIDTH-1:0] req_wdata,
    input logic [WIDTH-1:0] req_mask,
    input logic             rd_valid,
    input logic [WIDTH-1:0] rd_data,
    input logic             wr_en,
    input logic [WIDTH-1:0] wr_word
);

    assert_rd_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid);

    assert_rd_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rd_valid);

    assert_wr_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> wr_en);

    assert_merge_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (((wr_word ^ $past(req_wdata)) & $past(req_mask)) == '0));

    assert_fwd_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && req_valid && !req_write && (req_addr == $past(req_addr)))
        |=> (rd_data == $past(wr_word)));

    assert_idle_no_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write) |=> !wr_en);

    assert_reset_quiet_R7: assert property (@(posedge clk)
        !rst_n |=> (!rd_valid && !wr_en));

endmodule

bind bitmask_ram bmram_chk #(
    .WIDTH (WIDTH),
    .AW    (AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_mask  (req_mask),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .wr_en     (wr_en),
    .wr_word   (wr_word)
);

// File: tb/tb_bitmask_ram.sv
`timescale 1ns/1ps
module tb_bitmask_ram;

    localparam int DEPTH = 128;
    localparam int WIDTH = 80;
    localparam int AW    = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_write = 1'b0;
    logic [AW-1:0]    req_addr = '0;
    logic [WIDTH-1:0] req_wdata = '0;
    logic [WIDTH-1:0] req_mask = '0;
    logic             rd_valid;
    logic [WIDTH-1:0] rd_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [WIDTH-1:0] model [DEPTH];

    always #2.5 clk = ~clk;

    bitmask_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_mask  (req_mask),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    function automatic logic [WIDTH-1:0] mkword(input logic [31:0] s);
        logic [WIDTH-1:0] r;
        for (int i = 0; i < WIDTH; i++) r[i] = s[i % 32] ^ s[(i * 7 + 3) % 32] ^ (i[0] & s[5]);
        return r;
    endfunction

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic check_word(input string req, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Each op: drive, then wait to the next falling edge, where its result is due.
    task automatic wr(input int a, input logic [WIDTH-1:0] d, input logic [WIDTH-1:0] m);
        req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(a); req_wdata = d; req_mask = m;
        model[a] = (model[a] & ~m) | (d & m);
        @(negedge clk);
        check_bit("R1 no rd_valid after write", rd_valid, 1'b0);
    endtask

    task automatic rd(input string req, input int a);
        req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a);
        req_wdata = mkword(32'hdead_0000 + a); req_mask = '1;
        @(negedge clk);
        check_bit({req, " rd_valid"}, rd_valid, 1'b1);
        check_word(req, rd_data, model[a]);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            req_valid = 1'b0; req_write = 1'b1; req_addr = '0;
            req_wdata = '1; req_mask = '1;
            @(negedge clk);
            check_bit("R9 idle rd_valid", rd_valid, 1'b0);
        end
    endtask

    task automatic t_reset();
        req_valid = 1'b1; req_write = 1'b0;
        repeat (3) @(negedge clk);
        check_bit("R7 rd_valid in reset", rd_valid, 1'b0);
        rst_n = 1'b1;
        idle(1);
    endtask

    task automatic t_basic();
        wr(5, mkword(32'h1234_5678), '1);
        idle(2);
        rd("R2 full write stored", 5);
        wr(5, mkword(32'h0f0f_aaaa), mkword(32'h00ff_3c3c));
        idle(1);
        rd("R2 masked merge stored", 5);
    endtask

    task automatic t_forward();
        wr(9, mkword(32'h5555_0001), '1);
        idle(2);
        wr(9, mkword(32'hcafe_f00d), mkword(32'h8421_7e7e));
        rd("R3 read right after write", 9);
        rd("R3 second read after forward", 9);
    endtask

    task automatic t_delay();
        wr(12, mkword(32'h0bad_beef), '1);
        wr(12, mkword(32'h7777_1111), mkword(32'hf000_000f));
        idle(1);
        rd("R4 read two cycles after write", 12);
        idle(3);
        rd("R4 read after long gap", 12);
    endtask

    task automatic t_b2b();
        wr(20, mkword(32'h0000_0000), '1);
        wr(20, mkword(32'hffff_ffff), mkword(32'h0000_ffff));
        wr(20, mkword(32'h1357_9bdf), mkword(32'h0f0f_0f0f));
        wr(20, mkword(32'h2468_ace0), mkword(32'hc000_0003));
        rd("R5 chained writes merged", 20);
    endtask

    task automatic t_masks();
        wr(30, mkword(32'h3141_5926), '1);
        idle(2);
        wr(30, mkword(32'hffff_0000), '0);
        idle(1);
        rd("R6 zero mask keeps word", 30);
        wr(30, mkword(32'h2718_2818), '0);
        rd("R6 zero mask forwarded", 30);
        wr(30, mkword(32'habcd_ef01), '1);
        rd("R6 all-ones mask replaces", 30);
    endtask

    task automatic t_other_addr();
        wr(40, mkword(32'h4040_4040), '1);
        wr(41, mkword(32'h4141_4141), '1);
        wr(40, mkword(32'h9999_6666), mkword(32'hffff_ffff));
        rd("R8 other address not forwarded", 41);
        wr(41, mkword(32'h1111_2222), mkword(32'h0000_ff00));
        wr(40, mkword(32'h0f0f_f0f0), mkword(32'h3333_cccc));
        rd("R8 address 41 after write to 40", 41);
        rd("R8 address 40 own content", 40);
    endtask

    task automatic t_idle_keep();
        wr(50, mkword(32'h5050_0505), '1);
        idle(4);
        rd("R9 idle cycles left word intact", 50);
    endtask

    task automatic t_stream();
        logic [31:0] lf = 32'hace1_2345;
        for (int a = 60; a < 68; a++) wr(a, mkword(32'h600d_0000 + a), '1);
        for (int i = 0; i < 300; i++) begin
            int a;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            a = 60 + int'(lf[2:0]);
            case (lf[9:8])
                2'd0, 2'd1: wr(a, mkword(lf), mkword({lf[15:0], lf[31:16]} ^ 32'h5a5a_a5a5));
                2'd2: rd("R1 mixed stream read", a);
                default: idle(1);
            endcase
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_forward();
        t_delay();
        t_b2b();
        t_masks();
        t_other_addr();
        t_idle_keep();
        t_stream();
        idle(1);
        done = 1'b1;
        finish_run();
    end

endmodule